// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block controls medium access on the transmit side of an Ethernet MAC. The host raises a one-cycle request. The block then keeps a pending flag and decides when a byte-serial transmit engine may start a frame. It counts the bytes the engine reports for the current attempt. It also tells the engine when to send a jam and when to stop. The system clock is the byte clock.

In half-duplex mode the block waits while carrier is present. A collision is handled in one of two ways, depending on how many bytes of the frame were already sent:
- Early collision: fewer bytes than a programmable window. The block jams, waits a random binary exponential backoff, then restarts the frame from its first byte. It does this up to a programmable retry limit.
- Late collision: at least as many bytes as the window. The block jams and then gives the frame up at once.

Every give-up sets a sticky abort flag and pulses an error interrupt. A frame that completes clears that flag and pulses a done output.

In full-duplex mode the block ignores carrier and collisions. The host can change the duplex mode only while no request is pending and the receiver reports idle.

Top module: `hdtx_retry_ctrl`

## Requirements
- R1: After synchronous reset, every output is 0. The mode is half duplex, the retry limit is 15 and the collision window is 55 bytes.
- R2: A `tx_req` pulse sets `tx_busy`. In half duplex `eng_start` pulses once, and only after `crs` has been low at a clock edge. While `crs` stays high, no start is issued.
- R3: In half duplex, a `col` seen during an attempt holds `eng_jam` high for exactly 4 cycles. `eng_halt` then pulses in the cycle after the last jam cycle.
- R4: After an early collision, a new `eng_start` comes 64·r + 2 cycles after the `eng_halt` pulse, where 0 ≤ r ≤ 2^min(n,10) − 1 and n is the number of collisions in this frame so far.
- R5: An early collision that occurs when the retry count already equals the programmed limit ends the frame instead of retrying. A limit of m therefore allows m + 1 attempts.
- R6: A collision after at least `cfg_coll_win` counted bytes ends the frame after the jam, with no new start.
- R7: Ending a frame after a collision clears `tx_busy`, sets `tx_abort` and pulses `tx_err_irq` for one cycle, all in the same cycle as `eng_halt`.
- R8: `eng_done` during an attempt clears `tx_busy` and `tx_abort` and pulses `tx_done`. It also resets the retry count, so the next frame gets the full retry limit again.
- R9: In full duplex, `eng_start` comes two cycles after the request regardless of `crs`, and `col` causes no jam.
- R10: A `cfg_wr` changes `duplex_full` only when `tx_busy` is low and `rx_idle` is high. The retry limit and window are taken on every `cfg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_full_duplex | input | 1 | Requested duplex mode (1 = full) |
| cfg_retry_max | input | 4 | Retransmission limit |
| cfg_coll_win | input | 6 | Collision window in bytes |
| rx_idle | input | 1 | Receiver is idle |
| tx_req | input | 1 | Transmit request pulse |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| eng_byte | input | 1 | Engine sent one byte this cycle |
| eng_done | input | 1 | Engine finished the frame |
| eng_start | output | 1 | Start frame from its first byte |
| eng_jam | output | 1 | Send jam |
| eng_halt | output | 1 | Stop the current attempt |
| tx_busy | output | 1 | Request pending |
| tx_abort | output | 1 | Sticky abort status |
| tx_err_irq | output | 1 | Transmit error interrupt pulse |
| tx_done | output | 1 | Frame sent pulse |
| duplex_full | output | 1 | Active duplex mode |

## Verification
The bench sweeps the collision window over small values and collides exactly one byte before and exactly at the window. An off-by-one compare would retry a late collision or abort an early one. It sweeps the retry limit from 0 to 3 and counts attempts before the abort. A design whose limit check is off by one, or that does not reset its retry count on success, gives one attempt too many or too few. It measures every backoff gap against the slot-multiple formula and the range bound, which catches a wrong mask or a wrong slot length. It also tries duplex changes while busy and while receiving, where a design that does not gate the change would switch modes.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XMIT,
    ST_JAM,
    ST_BACKOFF
  } hdtx_state_t;
endpackage

// File: rtl/hdtx_lfsr.sv
module hdtx_lfsr #(
  parameter int W     = 16,
  parameter int OUT_W = 10,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] sr;

  // Galois form: shift right, fold taps back in when the dropped bit is 1
  always_ff @(posedge clk) begin
    if (rst) sr <= SEED;
    else     sr <= (sr >> 1) ^ (sr[0] ? TAPS : '0);
  end

  assign rnd = sr[OUT_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    sr != '0); // R4
endmodule

// File: rtl/hdtx_backoff.sv
module hdtx_backoff #(
  parameter int CN_W       = 5,
  parameter int EXP_CAP    = 10,
  parameter int SLOT_TICKS = 64,
  localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CN_W-1:0]    coll_num,
  input  logic [EXP_CAP-1:0] rnd,
  output logic               idle
);
  int unsigned        exp_v;
  logic [EXP_CAP-1:0] mask;
  logic [EXP_CAP-1:0] slots;
  logic [EXP_CAP-1:0] slot_left;
  logic [TICK_W-1:0]  tick;
  logic               active;

  always_comb begin
    exp_v = (int'(coll_num) > EXP_CAP) ? EXP_CAP : int'(coll_num);
    mask  = EXP_CAP'((32'd1 << exp_v) - 32'd1);
    slots = rnd & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_left <= '0;
      tick      <= '0;
      active    <= 1'b0;
    end else if (load) begin
      slot_left <= slots;
      tick      <= '0;
      active    <= (slots != '0);
    end else if (active) begin
      if (tick == TICK_W'(SLOT_TICKS - 1)) begin
        tick      <= '0;
        slot_left <= slot_left - 1'b1;
        if (slot_left == EXP_CAP'(1)) active <= 1'b0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign idle = ~active;

  AST_BO_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    active |-> (slot_left != '0)); // R4
endmodule

// File: rtl/hdtx_retry_ctrl.sv
module hdtx_retry_ctrl #(
  parameter int RMAX_W        = 4,
  parameter int WIN_W         = 6,
  parameter int JAM_TICKS     = 4,
  parameter int SLOT_TICKS    = 64,
  parameter int EXP_CAP       = 10,
  parameter int LFSR_W        = 16,
  parameter int DEF_RETRY_MAX = 15,
  parameter int DEF_COLL_WIN  = 55,
  localparam int CN_W         = RMAX_W + 1,
  localparam int JCNT_W       = $clog2(JAM_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_full_duplex,
  input  logic [RMAX_W-1:0] cfg_retry_max,
  input  logic [WIN_W-1:0]  cfg_coll_win,
  input  logic              rx_idle,
  input  logic              tx_req,
  input  logic              crs,
  input  logic              col,
  input  logic              eng_byte,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_jam,
  output logic              eng_halt,
  output logic              tx_busy,
  output logic              tx_abort,
  output logic              tx_err_irq,
  output logic              tx_done,
  output logic              duplex_full
);
  import hdtx_pkg::*;

  hdtx_state_t        state;
  logic [RMAX_W-1:0]  retry_max;
  logic [WIN_W-1:0]   coll_win;
  logic [RMAX_W-1:0]  retry_cnt;
  logic [WIN_W-1:0]   byte_cnt;
  logic [JCNT_W-1:0]  jam_cnt;
  logic               late;
  logic               jam_last;
  logic               give_up;
  logic               bo_load;
  logic               bo_idle;
  logic [CN_W-1:0]    coll_num;
  logic [EXP_CAP-1:0] rnd;

  assign jam_last = (jam_cnt == JCNT_W'(JAM_TICKS - 1));
  assign give_up  = late || (retry_cnt == retry_max);
  assign bo_load  = (state == ST_JAM) && jam_last && !give_up;
  assign coll_num = CN_W'(retry_cnt) + CN_W'(1);
  assign eng_jam  = (state == ST_JAM);

  hdtx_lfsr #(.W(LFSR_W), .OUT_W(EXP_CAP)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  hdtx_backoff #(.CN_W(CN_W), .EXP_CAP(EXP_CAP), .SLOT_TICKS(SLOT_TICKS)) u_backoff (
    .clk(clk), .rst(rst), .load(bo_load), .coll_num(coll_num),
    .rnd(rnd), .idle(bo_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      retry_max   <= RMAX_W'(DEF_RETRY_MAX);
      coll_win    <= WIN_W'(DEF_COLL_WIN);
      duplex_full <= 1'b0;
      retry_cnt   <= '0;
      byte_cnt    <= '0;
      jam_cnt     <= '0;
      late        <= 1'b0;
      tx_busy     <= 1'b0;
      tx_abort    <= 1'b0;
      eng_start   <= 1'b0;
      eng_halt    <= 1'b0;
      tx_err_irq  <= 1'b0;
      tx_done     <= 1'b0;
    end else begin
      eng_start  <= 1'b0;
      eng_halt   <= 1'b0;
      tx_err_irq <= 1'b0;
      tx_done    <= 1'b0;
      if (cfg_wr) begin
        retry_max <= cfg_retry_max;
        coll_win  <= cfg_coll_win;
        if (!tx_busy && rx_idle) duplex_full <= cfg_full_duplex;
      end
      case (state)
        ST_IDLE: if (tx_req) begin
          tx_busy <= 1'b1;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (duplex_full || !crs) begin
          eng_start <= 1'b1;
          byte_cnt  <= '0;
          state     <= ST_XMIT;
        end
        ST_XMIT: begin
          if (eng_done) begin
            tx_busy   <= 1'b0;
            tx_abort  <= 1'b0;
            tx_done   <= 1'b1;
            retry_cnt <= '0;
            state     <= ST_IDLE;
          end else if (!duplex_full && col) begin
            late    <= (byte_cnt >= coll_win);
            jam_cnt <= '0;
            state   <= ST_JAM;
          end else if (eng_byte && byte_cnt != '1) begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_JAM: begin
          jam_cnt <= jam_cnt + 1'b1;
          if (jam_last) begin
            eng_halt <= 1'b1;
            if (give_up) begin
              tx_busy    <= 1'b0;
              tx_abort   <= 1'b1;
              tx_err_irq <= 1'b1;
              retry_cnt  <= '0;
              state      <= ST_IDLE;
            end else begin
              retry_cnt <= retry_cnt + 1'b1;
              state     <= ST_BACKOFF;
            end
          end
        end
        ST_BACKOFF: if (bo_idle) state <= ST_WAIT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_AFTER_IDLE_MEDIUM: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !duplex_full) |-> !$past(crs)); // R2
  AST_HALT_FOLLOWS_JAM: assert property (@(posedge clk) disable iff (rst)
    eng_halt |-> $past(eng_jam)); // R3
  AST_IRQ_WITH_ABORT: assert property (@(posedge clk) disable iff (rst)
    tx_err_irq |-> (tx_abort && !tx_busy && eng_halt)); // R7
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_busy && !tx_abort)); // R8
  AST_FULL_NO_JAM: assert property (@(posedge clk) disable iff (rst)
    (duplex_full && $past(duplex_full) && $past(state) == ST_XMIT) |-> !eng_jam); // R9
  AST_DUPLEX_HELD: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(duplex_full)); // R10
endmodule

// File: tb/test_hdtx_retry_ctrl.sv
module test_hdtx_retry_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_full_duplex = 1'b0;
  logic [3:0] cfg_retry_max = 4'd15;
  logic [5:0] cfg_coll_win = 6'd55;
  logic       rx_idle = 1'b1, tx_req = 1'b0, crs = 1'b0, col = 1'b0;
  logic       eng_byte = 1'b0, eng_done = 1'b0;
  logic       eng_start, eng_jam, eng_halt, tx_busy, tx_abort, tx_err_irq, tx_done, duplex_full;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hdtx_retry_ctrl i_hdtx_retry_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_full_duplex(cfg_full_duplex),
    .cfg_retry_max(cfg_retry_max), .cfg_coll_win(cfg_coll_win), .rx_idle(rx_idle),
    .tx_req(tx_req), .crs(crs), .col(col), .eng_byte(eng_byte), .eng_done(eng_done),
    .eng_start(eng_start), .eng_jam(eng_jam), .eng_halt(eng_halt), .tx_busy(tx_busy),
    .tx_abort(tx_abort), .tx_err_irq(tx_err_irq), .tx_done(tx_done), .duplex_full(duplex_full)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input bit fd, input int rmax, input int win);
    cfg_full_duplex = fd;
    cfg_retry_max   = 4'(rmax);
    cfg_coll_win    = 6'(win);
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  // request and wait for start; returns number of ticks after the request edge
  task automatic req_start(output int waited);
    tx_req = 1'b1;
    tick();
    tx_req = 1'b0;
    waited = 0;
    while (!eng_start && waited < 3000) begin
      tick();
      waited++;
    end
  endtask

  task automatic send_bytes(input int k);
    for (int i = 0; i < k; i++) begin
      eng_byte = 1'b1;
      tick();
    end
    eng_byte = 1'b0;
  endtask

  task automatic collide();
    int n;
    col = 1'b1;
    tick();
    col = 1'b0;
    n = 0;
    while (eng_jam && n < 20) begin
      n++;
      tick();
    end
    chk(n == 4, "R3 jam length", n, 4);
    chk(eng_halt == 1'b1, "R3 halt after jam", eng_halt, 1);
  endtask

  task automatic backoff_gap(input int ncoll);
    int d, lim, r;
    d = 0;
    while (!eng_start && d < 70000) begin
      tick();
      d++;
    end
    lim = (1 << ((ncoll > 10) ? 10 : ncoll)) - 1;
    r = (d - 2) / 64;
    chk(d >= 2 && ((d - 2) % 64) == 0, "R4 gap slot multiple", d, 64 * r + 2);
    chk(r <= lim, "R4 slot count range", r, lim);
  endtask

  task automatic finish_ok(input string req);
    eng_done = 1'b1;
    tick();
    eng_done = 1'b0;
    chk(tx_done == 1'b1, req, tx_done, 1);
    chk(tx_busy == 1'b0 && tx_abort == 1'b0, req, {tx_busy, tx_abort}, 0);
    tick();
    chk(tx_done == 1'b0, "R8 done one pulse", tx_done, 0);
  endtask

  task automatic expect_abort(input string req);
    chk(tx_err_irq && tx_abort && !tx_busy, req, {tx_err_irq, tx_abort, tx_busy}, 6);
    tick();
    chk(tx_err_irq == 1'b0 && tx_abort == 1'b1, "R7 irq pulse sticky abort", {tx_err_irq, tx_abort}, 1);
  endtask

  task automatic expect_no_start(input int cycles, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (eng_start) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++;
      vecs++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int w;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk({eng_start, eng_jam, eng_halt, tx_busy, tx_abort, tx_err_irq, tx_done, duplex_full} == 8'd0,
        "R1 reset outputs", {eng_start, eng_jam, eng_halt, tx_busy, tx_abort, tx_err_irq, tx_done, duplex_full}, 0);

    // R2 defer while carrier present
    crs = 1'b1;
    tx_req = 1'b1; tick(); tx_req = 1'b0;
    chk(tx_busy == 1'b1, "R2 busy set", tx_busy, 1);
    expect_no_start(10, "R2 no start while carrier");
    crs = 1'b0;
    tick();
    chk(eng_start == 1'b1, "R2 start once idle", eng_start, 1);
    // R1 default window 55: 54 bytes early
    send_bytes(54);
    collide();
    chk(tx_busy && !tx_abort && !tx_err_irq, "R1 default window early", {tx_busy, tx_abort, tx_err_irq}, 4);
    backoff_gap(1);
    send_bytes(55);
    collide();
    expect_abort("R6 default window late");
    expect_no_start(300, "R6 no retry after late");

    // window sweep, R3 R6
    for (int wi = 1; wi <= 6; wi++) begin
      w = wi;
      do_cfg(1'b0, 15, w);
      req_start(w);
      send_bytes(wi - 1);
      collide();
      chk(tx_busy && !tx_err_irq, "R3 early retries", {tx_busy, tx_err_irq}, 2);
      backoff_gap(1);
      finish_ok("R8 success after retry");
      req_start(w);
      send_bytes(wi);
      collide();
      expect_abort("R6 late abort at window");
      expect_no_start(80, "R6 no restart");
    end

    // retry limit sweep, R5
    for (int m = 0; m <= 3; m++) begin
      do_cfg(1'b0, m, 5);
      req_start(w);
      for (int i = 0; i <= m; i++) begin
        collide();
        if (i < m) begin
          chk(tx_busy == 1'b1, "R5 retry below limit", tx_busy, 1);
          backoff_gap(i + 1);
        end else begin
          expect_abort("R5 abort at limit");
        end
      end
      expect_no_start(80, "R5 no attempt beyond limit");
    end

    // R8 retry count reset by success
    do_cfg(1'b0, 1, 5);
    req_start(w);
    collide();
    backoff_gap(1);
    finish_ok("R8 clears abort");
    req_start(w);
    collide();
    chk(tx_busy == 1'b1 && tx_err_irq == 1'b0, "R8 retry count reset", {tx_busy, tx_err_irq}, 2);
    backoff_gap(1);
    finish_ok("R8 done");

    // R10 duplex change gating
    tx_req = 1'b1; crs = 1'b1; tick(); tx_req = 1'b0;
    do_cfg(1'b1, 15, 55);
    chk(duplex_full == 1'b0, "R10 ignored while busy", duplex_full, 0);
    crs = 1'b0;
    tick();
    finish_ok("R8 done");
    rx_idle = 1'b0;
    do_cfg(1'b1, 15, 55);
    chk(duplex_full == 1'b0, "R10 ignored while receiving", duplex_full, 0);
    rx_idle = 1'b1;
    do_cfg(1'b1, 15, 55);
    chk(duplex_full == 1'b1, "R10 accepted when quiet", duplex_full, 1);

    // R9 full duplex ignores carrier and collisions
    crs = 1'b1;
    tx_req = 1'b1; tick(); tx_req = 1'b0;
    tick();
    chk(eng_start == 1'b1, "R9 start ignoring carrier", eng_start, 1);
    send_bytes(60);
    col = 1'b1;
    begin
      int jams;
      jams = 0;
      for (int i = 0; i < 10; i++) begin
        tick();
        if (eng_jam || eng_halt) jams++;
      end
      chk(jams == 0, "R9 no jam in full duplex", jams, 0);
    end
    col = 1'b0;
    crs = 1'b0;
    finish_ok("R9 completes");
    do_cfg(1'b0, 15, 55);
    chk(duplex_full == 1'b0, "R10 back to half", duplex_full, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule